// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register storage of a processor core. Software names 32 registers with a 5-bit index. Indices 0 to 7 are global and name the same storage whatever the current context. Indices 8 to 31 are translated through a movable window over a larger physical array, which holds 8 globals plus 16 registers for each implemented window. A window pointer, advanced by a call-style command and pulled back by a return-style command, selects the window. Each window owns 8 locals. Its 8 outgoing-argument registers are the incoming-argument registers of the window a call moves into, so a call passes arguments without any copying.

Index 8 to 15 are the outs, 16 to 23 the locals and 24 to 31 the ins. The ins of window p are the outs of window (p+1) mod NWIN, and a call moves the pointer from p to (p-1) mod NWIN. Software supplies a per-window invalid mask. A command that would enter a marked window leaves the pointer where it is and raises an overflow flag (call) or an underflow flag (return) for one cycle. Trap software can then spill or fill windows and retry. There are two read ports with registered outputs and one write port. The storage is written so that block RAM can be inferred.

Top module: `wreg_file`

## Requirements
- R1: Indices 1 to 7 name the same global registers in every window, so a value written in one window reads back unchanged after any number of window moves.
- R2: Index 0 always reads as zero, and a write to index 0 is discarded, including on the same-cycle bypass path.
- R3: Indices 16 to 23 are locals private to the current window, so writes made in another window leave them unchanged.
- R4: Indices 8 to 15 of window p are the same physical registers as indices 24 to 31 of window (p-1) mod NWIN. A value written as an out before a call reads back as the matching in after it, and the reverse holds after the return.
- R5: The 2-bit command encodes 01 as call, 10 as return, and 00 or 11 as no operation. An accepted call sets the pointer to (p-1) mod NWIN and an accepted return sets it to (p+1) mod NWIN. The new value appears on win_ptr after the clock edge that samples the command.
- R6: The pointer wraps modulo NWIN in both directions (0 to NWIN-1 on a call, NWIN-1 to 0 on a return).
- R7: A call whose target window has its bit set in win_invalid leaves the pointer unchanged and raises win_ovf for exactly the one cycle after that edge.
- R8: A return whose target window has its bit set in win_invalid leaves the pointer unchanged and raises win_unf for exactly the one cycle after that edge.
- R9: A read index is sampled on a clock edge, and its data is presented on the read output after that edge and held until the next edge.
- R10: A read whose index resolves to the physical register that is being written in the same cycle returns the new write data.
- R11: Synchronous active-high reset sets the pointer to 0, clears both flags and clears both read outputs.
- R12: Reads and a write issued in the same cycle as a call or return are translated through the window that is current before the command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | XLEN | Read port A data, registered |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | XLEN | Read port B data, registered |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | XLEN | Write data |
| win_cmd | input | 2 | Window command: 01 call, 10 return, else none |
| win_invalid | input | NWIN | One bit per window, set when that window is not resident |
| win_ptr | output | $clog2(NWIN) | Current window pointer |
| win_ovf | output | 1 | One-cycle pulse when a call is refused |
| win_unf | output | 1 | One-cycle pulse when a return is refused |

## Verification
The bench goes after the overlap between neighbouring windows. If the ins were tied to the wrong neighbour, an argument written before a call would read back as stale data in the callee. It checks the pointer wrap at both ends, where a missing modulo would step outside the array. It checks refused commands: a design that still moved the pointer, or that held the flag for more than one cycle, would show a wrong win_ptr or a stuck flag. It also checks bypass to index 0, reads during a window move that must use the old window, and writes that must not leak between windows' locals.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    WCMD_IDLE  = 2'b00,
    WCMD_CALL  = 2'b01,
    WCMD_RET   = 2'b10,
    WCMD_SPARE = 2'b11
  } wcmd_e;

  localparam int NUM_GLOBALS = 8;
  localparam int REGS_PER_WIN = 16;
  localparam int IDX_W = 5;
endpackage

// File: rtl/wrf_map.sv
// Translates an architectural register index into a physical array address.
module wrf_map #(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PW   = 8
) (
  input  logic [CW-1:0] cwp,
  input  logic [4:0]    idx,
  output logic [PW-1:0] phys
);
  logic [CW:0]   cwp_up;
  logic [CW-1:0] win;
  logic          is_local;

  always_comb begin
    cwp_up = {1'b0, cwp} + 1'b1;
    if (idx[4:3] == 2'b11) begin
      // ins belong to the neighbour window at pointer+1
      win = (cwp_up == (CW+1)'(NWIN)) ? '0 : cwp_up[CW-1:0];
    end else begin
      win = cwp;
    end
    is_local = (idx[4:3] == 2'b10);
    if (idx[4:3] == 2'b00) begin
      phys = PW'(idx);
    end else begin
      phys = PW'(wrf_pkg::NUM_GLOBALS) + PW'({win, 4'b0000}) + PW'({is_local, idx[2:0]});
    end
  end
endmodule

// File: rtl/wrf_cwp.sv
// Window pointer with refusal flags.
module wrf_cwp #(
  parameter int NWIN = 8,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cmd,
  input  logic [NWIN-1:0] invalid,
  output logic [CW-1:0]   cwp,
  output logic            ovf,
  output logic            unf
);
  import wrf_pkg::*;

  logic [CW-1:0] dn_ptr;
  logic [CW-1:0] up_ptr;

  always_comb begin
    dn_ptr = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
    up_ptr = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      case (wcmd_e'(cmd))
        WCMD_CALL: begin
          if (invalid[dn_ptr]) ovf <= 1'b1;
          else                 cwp <= dn_ptr;
        end
        WCMD_RET: begin
          if (invalid[up_ptr]) unf <= 1'b1;
          else                 cwp <= up_ptr;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wrf_store.sv
// Physical storage: one write port, NRD registered read ports with bypass.
module wrf_store #(
  parameter int XLEN  = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int NRD   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NRD-1:0][PW-1:0]   rphys,
  output logic [NRD-1:0][XLEN-1:0] rdata,
  input  logic                     we,
  input  logic [PW-1:0]            wphys,
  input  logic [XLEN-1:0]          wdata
);
  logic [XLEN-1:0] mem [NPHYS];
  logic            wr_live;

  assign wr_live = we && (wphys != '0);

  always_ff @(posedge clk) begin
    if (wr_live) mem[wphys] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                           q <= '0;
      else if (rphys[p] == '0)           q <= '0;
      else if (wr_live && wphys == rphys[p]) q <= wdata;
      else                               q <= mem[rphys[p]];
    end
    assign rdata[p] = q;
  end
endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int XLEN = 32,
  parameter int NWIN = 8,
  localparam int CW    = $clog2(NWIN),
  localparam int NPHYS = wrf_pkg::NUM_GLOBALS + wrf_pkg::REGS_PER_WIN * NWIN,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      win_cmd,
  input  logic [NWIN-1:0] win_invalid,
  output logic [CW-1:0]   win_ptr,
  output logic            win_ovf,
  output logic            win_unf
);
  localparam int NPORT = 3;

  logic [4:0]              arch_idx [NPORT];
  logic [PW-1:0]           phys_idx [NPORT];
  logic [1:0][PW-1:0]      rd_phys;
  logic [1:0][XLEN-1:0]    rd_q;

  assign arch_idx[0] = rd_a_idx;
  assign arch_idx[1] = rd_b_idx;
  assign arch_idx[2] = wr_idx;

  wrf_cwp #(.NWIN(NWIN), .CW(CW)) u_cwp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (win_cmd),
    .invalid (win_invalid),
    .cwp     (win_ptr),
    .ovf     (win_ovf),
    .unf     (win_unf)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .cwp  (win_ptr),
      .idx  (arch_idx[g]),
      .phys (phys_idx[g])
    );
  end

  assign rd_phys[0] = phys_idx[0];
  assign rd_phys[1] = phys_idx[1];

  wrf_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(2)) u_store (
    .clk   (clk),
    .rst   (rst),
    .rphys (rd_phys),
    .rdata (rd_q),
    .we    (wr_en),
    .wphys (phys_idx[2]),
    .wdata (wr_data)
  );

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int XLEN = 32,
  parameter int NWIN = 8,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [4:0]      rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic [4:0]      wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic [1:0]      win_cmd,
  input logic [NWIN-1:0] win_invalid,
  input logic [CW-1:0]   win_ptr,
  input logic            win_ovf,
  input logic            win_unf
);
  logic            live_q;
  logic [CW-1:0]   ptr_q;
  logic [1:0]      cmd_q;
  logic [NWIN-1:0] inv_q;
  logic [4:0]      ra_q;
  logic [4:0]      rb_q;
  logic            byp_q;
  logic [XLEN-1:0] wd_q;

  function automatic logic [CW-1:0] step_dn(input logic [CW-1:0] p);
    return (p == '0) ? CW'(NWIN - 1) : p - 1'b1;
  endfunction

  function automatic logic [CW-1:0] step_up(input logic [CW-1:0] p);
    return (p == CW'(NWIN - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
    ptr_q <= win_ptr;
    cmd_q <= win_cmd;
    inv_q <= win_invalid;
    ra_q  <= rd_a_idx;
    rb_q  <= rd_b_idx;
    byp_q <= wr_en && (wr_idx == rd_a_idx) && (wr_idx != 5'd0);
    wd_q  <= wr_data;
  end

  p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
    (live_q && ra_q == 5'd0) |-> rd_a_data == '0);
  p_zero_b_r2: assert property (@(posedge clk) disable iff (rst)
    (live_q && rb_q == 5'd0) |-> rd_b_data == '0);
  p_bypass_r10: assert property (@(posedge clk) disable iff (rst)
    (live_q && byp_q) |-> rd_a_data == wd_q);
  p_call_move_r5: assert property (@(posedge clk) disable iff (rst)
    (live_q && cmd_q == 2'b01 && !inv_q[step_dn(ptr_q)]) |-> (win_ptr == step_dn(ptr_q) && !win_ovf));
  p_ret_move_r5: assert property (@(posedge clk) disable iff (rst)
    (live_q && cmd_q == 2'b10 && !inv_q[step_up(ptr_q)]) |-> (win_ptr == step_up(ptr_q) && !win_unf));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (live_q && (cmd_q == 2'b00 || cmd_q == 2'b11)) |-> (win_ptr == ptr_q && !win_ovf && !win_unf));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (live_q && cmd_q == 2'b01 && inv_q[step_dn(ptr_q)]) |-> (win_ovf && win_ptr == ptr_q));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (live_q && cmd_q == 2'b10 && inv_q[step_up(ptr_q)]) |-> (win_unf && win_ptr == ptr_q));
  p_flag_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(win_ovf && win_unf));
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (rst)
    live_q |-> win_ptr <= CW'(NWIN - 1));
  p_reset_state_r11: assert property (@(posedge clk)
    $past(rst) |-> (win_ptr == '0 && !win_ovf && !win_unf && rd_a_data == '0 && rd_b_data == '0));
endmodule

bind wreg_file wrf_checker #(.XLEN(XLEN), .NWIN(NWIN), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .win_cmd     (win_cmd),
  .win_invalid (win_invalid),
  .win_ptr     (win_ptr),
  .win_ovf     (win_ovf),
  .win_unf     (win_unf)
);

// File: tb/tb_wreg_file.sv
module tb_wreg_file;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NWIN = 8;
  localparam int CW   = $clog2(NWIN);
  localparam logic [1:0] C_IDLE = 2'b00, C_CALL = 2'b01, C_RET = 2'b10, C_SPARE = 2'b11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [4:0]      rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      win_cmd = '0;
  logic [NWIN-1:0] win_invalid = '0;
  logic [CW-1:0]   win_ptr;
  logic            win_ovf, win_unf;

  wreg_file #(.XLEN(XLEN), .NWIN(NWIN)) dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .win_cmd(win_cmd), .win_invalid(win_invalid),
    .win_ptr(win_ptr), .win_ovf(win_ovf), .win_unf(win_unf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // scoreboard queues, one entry per driven cycle
  bit              q_ca[$], q_cb[$], q_ovf[$], q_unf[$];
  logic [XLEN-1:0] q_ea[$], q_eb[$];
  logic [CW-1:0]   q_ptr[$];
  string           q_tag[$];

  int n_cmp = 0;
  int n_bad = 0;
  logic [CW-1:0] m_ptr = '0;

  task automatic compare(input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(input logic [4:0] ra, input logic [4:0] rb,
                      input bit we, input logic [4:0] wi, input logic [XLEN-1:0] wd,
                      input logic [1:0] cmd,
                      input bit ca, input logic [XLEN-1:0] ea,
                      input bit cb, input logic [XLEN-1:0] eb,
                      input string tag);
    bit o = 0;
    bit u = 0;
    logic [CW-1:0] nx;
    rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd;
    win_cmd = cmd;
    if (rst) m_ptr = '0;
    else if (cmd == C_CALL) begin
      nx = (m_ptr == 0) ? CW'(NWIN-1) : m_ptr - 1'b1;
      if (win_invalid[nx]) o = 1; else m_ptr = nx;
    end else if (cmd == C_RET) begin
      nx = (m_ptr == CW'(NWIN-1)) ? '0 : m_ptr + 1'b1;
      if (win_invalid[nx]) u = 1; else m_ptr = nx;
    end
    q_ca.push_back(ca); q_ea.push_back(ea);
    q_cb.push_back(cb); q_eb.push_back(eb);
    q_ptr.push_back(m_ptr); q_ovf.push_back(o); q_unf.push_back(u);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: pops one entry after each edge that consumed a driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_tag.size() > 0) begin
        string t;
        bit ca, cb, o, u;
        logic [XLEN-1:0] ea, eb;
        logic [CW-1:0] p;
        t = q_tag.pop_front();
        ca = q_ca.pop_front(); ea = q_ea.pop_front();
        cb = q_cb.pop_front(); eb = q_eb.pop_front();
        p = q_ptr.pop_front(); o = q_ovf.pop_front(); u = q_unf.pop_front();
        if (ca) compare(t, "rd_a_data", rd_a_data, ea);
        if (cb) compare(t, "rd_b_data", rd_b_data, eb);
        compare(t, "win_ptr", XLEN'(win_ptr), XLEN'(p));
        compare(t, "win_ovf", XLEN'(win_ovf), XLEN'(o));
        compare(t, "win_unf", XLEN'(win_unf), XLEN'(u));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11: outputs and pointer cleared under reset
    step(1, 2, 0, 0, 0, C_CALL, 1, 0, 1, 0, "R11");
    step(3, 4, 0, 0, 0, C_RET, 1, 0, 1, 0, "R11");
    rst = 1'b0;
    // globals and index 0
    step(0, 0, 1, 1, 32'h11, C_IDLE, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 5, 32'h55, C_IDLE, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 32'hDEAD, C_IDLE, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 0, C_IDLE, 1, 0, 1, 32'h11, "R2");
    // R10: bypass on a live register
    step(7, 5, 1, 7, 32'h77, C_IDLE, 1, 32'h77, 1, 32'h55, "R10");
    // R2: bypass never applies to index 0
    step(0, 7, 1, 0, 32'hBEEF, C_IDLE, 1, 0, 1, 32'h77, "R2");
    // window 0: out0, local0, in0
    step(0, 0, 1, 8, 32'hA0, C_IDLE, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 16, 32'hB0, C_IDLE, 0, 0, 0, 0, "R9");
    step(8, 0, 1, 24, 32'hC0, C_IDLE, 1, 32'hA0, 0, 0, "R9");
    step(16, 24, 0, 0, 0, C_IDLE, 1, 32'hB0, 1, 32'hC0, "R9");
    // R12: reads and write alongside a call use window 0; pointer 0 -> 7 (R6)
    step(16, 24, 1, 17, 32'h17, C_CALL, 1, 32'hB0, 1, 32'hC0, "R12");
    // R4: in0 of window 7 is out0 of window 0
    step(24, 1, 1, 16, 32'hD7, C_IDLE, 1, 32'hA0, 1, 32'h11, "R4");
    // R1: globals visible in window 7; write in1 of window 7
    step(16, 5, 1, 25, 32'hE1, C_IDLE, 1, 32'hD7, 1, 32'h55, "R1");
    step(0, 0, 0, 0, 0, C_RET, 0, 0, 0, 0, "R5");
    // R3: local of window 0 untouched by window 7 writes; R4 reverse direction
    step(16, 9, 0, 0, 0, C_IDLE, 1, 32'hB0, 1, 32'hE1, "R3");
    step(17, 24, 0, 0, 0, C_IDLE, 1, 32'h17, 1, 32'hC0, "R12");
    // R7: call into an invalid window is refused
    win_invalid = 8'h80;
    step(0, 0, 0, 0, 0, C_CALL, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, C_IDLE, 0, 0, 0, 0, "R7");
    // R8: return into an invalid window is refused
    win_invalid = 8'h02;
    step(0, 0, 0, 0, 0, C_RET, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, C_IDLE, 0, 0, 0, 0, "R8");
    win_invalid = '0;
    step(0, 0, 0, 0, 0, C_RET, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, C_SPARE, 0, 0, 0, 0, "R5");
    // R6: walk upward through the top and wrap to 0
    for (int k = 0; k < NWIN - 1; k++) begin
      step(0, 0, 0, 0, 0, C_RET, 0, 0, 0, 0, "R6");
    end
    step(16, 1, 0, 0, 0, C_CALL, 1, 32'hB0, 1, 32'h11, "R6");
    step(0, 0, 0, 0, 0, C_IDLE, 0, 0, 0, 0, "R6");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule